// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Controller

This block is the control core of a static RAM that holds a shadow copy of its contents in nonvolatile cells. It watches the read traffic on the memory bus, timed by falling edges of the active-low chip enable, for a fixed unlock pattern. The pattern is five fixed addresses followed by a sixth address that selects the operation. When the pattern completes, the block starts a save (SRAM to nonvolatile cells) or a restore (nonvolatile cells to SRAM). The cycle then runs for a set number of clocks without any further help from the bus.

While a cycle runs, the block keeps the data drivers off and ignores every bus input. When the supply-good indication rises, it starts a restore by itself. A drop of that indication cancels a save that is running, but a restore always runs to its end. The memory array, the nonvolatile cells and the supply comparator lie outside the block. They appear only as the activity levels, the completion pulses and the supply-good input.

The chip enable, write enable and address are taken through a synchronizer of `SYNC_STAGES` flops. Each falling edge of the synchronized chip enable counts as one bus access.

Top module: `nvsram_seq_ctrl`

## Requirements
- R1: While reset is applied and directly after it, with supply-good low, `busy_o`, `store_act_o`, `recall_act_o`, `store_done_o`, `recall_done_o` and `store_abort_o` are all 0.
- R2: On every low-to-high change of `pwr_ok_i` while idle, a restore starts by itself. `recall_act_o` and `busy_o` stay high for exactly `RECALL_CYC` clocks, and `recall_done_o` is high for the single clock that follows.
- R3: Six consecutive read accesses to `UNLK0`, `UNLK1`, `UNLK2`, `UNLK3`, `UNLK4` and then `SEL_STORE` start a save. `store_act_o` and `busy_o` stay high for exactly `STORE_CYC` clocks, followed by a one-clock `store_done_o`.
- R4: The same five unlock reads followed by a read of `SEL_RECALL` start a restore with the timing of R2.
- R5: If the sixth read matches neither `SEL_STORE` nor `SEL_RECALL`, no cycle starts and the matcher returns to its first step.
- R6: Repeating an address, or reading the unlock addresses out of order, returns the matcher to its first step, so no cycle starts.
- R7: An access with `we_n_i` low at the chip-enable falling edge is a write. It returns the matcher to its first step and never counts as a step.
- R8: A chip-enable low pulse of a single clock counts as a full access step.
- R9: During a cycle, chip-enable activity has no effect. A complete unlock pattern presented while busy starts nothing afterwards.
- R10: `dq_oe_o` is 1 only when the block is idle, `ce_n_i` and `oe_n_i` are low and `we_n_i` is high. It is 0 during any cycle.
- R11: If `pwr_ok_i` is low during a save, the save ends at the next clock with a one-clock `store_abort_o` and no `store_done_o`.
- R12: A drop of `pwr_ok_i` during a restore does not shorten it.
- R13: While `pwr_ok_i` is low, a complete store pattern starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Memory address bus |
| ce_n_i | input | 1 | Chip enable, active low; its falling edge marks one access |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low; does not affect pattern matching |
| pwr_ok_i | input | 1 | Supply above the switch threshold |
| busy_o | output | 1 | A save or restore is running |
| store_act_o | output | 1 | Save running (to the nonvolatile cells) |
| recall_act_o | output | 1 | Restore running (to the SRAM array) |
| store_done_o | output | 1 | One-clock pulse when a save ends normally |
| recall_done_o | output | 1 | One-clock pulse when a restore ends |
| store_abort_o | output | 1 | One-clock pulse when a save is cancelled by supply loss |
| dq_oe_o | output | 1 | Enable for the data output drivers |

## Verification
The assertions assume that `pwr_ok_i` changes only between clock edges, and that address and write enable stay steady while chip enable is low. Under that assumption the synchronized bundle stays consistent, and each low pulse gives exactly one access event. The bench changes every input at the falling clock edge. It holds address and write enable for the whole low pulse and keeps chip enable high for at least three clocks between accesses. It changes `pwr_ok_i` only at falling edges, so each save or restore begins and ends on a known clock.

// File: rtl/nvseq_pkg.sv
`timescale 1ns/1ps
package nvseq_pkg;
   typedef enum logic [1:0] {
      NV_IDLE   = 2'd0,
      NV_STORE  = 2'd1,
      NV_RECALL = 2'd2
   } nv_state_e;

   typedef enum logic [1:0] {
      REQ_NONE   = 2'd0,
      REQ_STORE  = 2'd1,
      REQ_RECALL = 2'd2
   } nv_req_e;
endpackage

// File: rtl/nvseq_sync.sv
`timescale 1ns/1ps
module nvseq_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
      assign q_o = stg[STAGES-1];
   end
endmodule

// File: rtl/nvseq_matcher.sv
`timescale 1ns/1ps
module nvseq_matcher
   import nvseq_pkg::*;
#(
   parameter int           AW         = 14,
   parameter logic [AW-1:0] UNLK0      = '0,
   parameter logic [AW-1:0] UNLK1      = '0,
   parameter logic [AW-1:0] UNLK2      = '0,
   parameter logic [AW-1:0] UNLK3      = '0,
   parameter logic [AW-1:0] UNLK4      = '0,
   parameter logic [AW-1:0] SEL_STORE  = '0,
   parameter logic [AW-1:0] SEL_RECALL = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          evt_i,
   input  logic          rd_i,
   input  logic [AW-1:0] addr_i,
   output nv_req_e       req_o
);
   localparam int STEPS = 5;
   localparam int SW    = $clog2(STEPS + 1);
   localparam logic [AW-1:0] UNLK_TAB [STEPS] = '{UNLK0, UNLK1, UNLK2, UNLK3, UNLK4};

   logic [SW-1:0]    step_q, step_d;
   logic [STEPS-1:0] hit;
   logic [STEPS-1:0] sel;
   logic             step_hit;

   for (genvar i = 0; i < STEPS; i++) begin : g_hit
      assign hit[i] = (addr_i == UNLK_TAB[i]);
   end

   assign sel      = STEPS'(1) << step_q;
   assign step_hit = |(hit & sel);

   always_comb begin
      step_d = step_q;
      req_o  = REQ_NONE;
      if (clear_i) begin
         step_d = '0;
      end else if (evt_i) begin
         if (!rd_i) begin
            step_d = '0;
         end else if (step_q == SW'(STEPS)) begin
            step_d = '0;
            if (addr_i == SEL_STORE)       req_o = REQ_STORE;
            else if (addr_i == SEL_RECALL) req_o = REQ_RECALL;
         end else if (step_hit) begin
            step_d = step_q + SW'(1);
         end else begin
            step_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_d;
   end
endmodule

// File: rtl/nvseq_cycle_ctrl.sv
`timescale 1ns/1ps
module nvseq_cycle_ctrl
   import nvseq_pkg::*;
#(
   parameter int STORE_CYC  = 2_000_000,
   parameter int RECALL_CYC = 4_000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    pwr_ok_i,
   input  nv_req_e req_i,
   output logic    store_act_o,
   output logic    recall_act_o,
   output logic    store_done_o,
   output logic    recall_done_o,
   output logic    store_abort_o
);
   localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   nv_state_e     st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          pwr_q;
   logic          pwr_rise;
   logic          sdone_d, rdone_d, abort_d;

   assign pwr_rise = pwr_ok_i & ~pwr_q;

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      sdone_d = 1'b0;
      rdone_d = 1'b0;
      abort_d = 1'b0;
      unique case (st_q)
         NV_IDLE: begin
            if (pwr_rise || req_i == REQ_RECALL) begin
               st_d  = NV_RECALL;
               cnt_d = CW'(RECALL_CYC - 1);
            end else if (req_i == REQ_STORE && pwr_ok_i) begin
               st_d  = NV_STORE;
               cnt_d = CW'(STORE_CYC - 1);
            end
         end
         NV_STORE: begin
            if (!pwr_ok_i) begin
               st_d    = NV_IDLE;
               abort_d = 1'b1;
            end else if (cnt_q == '0) begin
               st_d    = NV_IDLE;
               sdone_d = 1'b1;
            end else begin
               cnt_d = cnt_q - CW'(1);
            end
         end
         NV_RECALL: begin
            if (cnt_q == '0) begin
               st_d    = NV_IDLE;
               rdone_d = 1'b1;
            end else begin
               cnt_d = cnt_q - CW'(1);
            end
         end
         default: st_d = NV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= NV_IDLE;
         cnt_q         <= '0;
         pwr_q         <= 1'b0;
         store_done_o  <= 1'b0;
         recall_done_o <= 1'b0;
         store_abort_o <= 1'b0;
      end else begin
         st_q          <= st_d;
         cnt_q         <= cnt_d;
         pwr_q         <= pwr_ok_i;
         store_done_o  <= sdone_d;
         recall_done_o <= rdone_d;
         store_abort_o <= abort_d;
      end
   end

   assign store_act_o  = (st_q == NV_STORE);
   assign recall_act_o = (st_q == NV_RECALL);
endmodule

// File: rtl/nvsram_seq_ctrl.sv
`timescale 1ns/1ps
module nvsram_seq_ctrl
   import nvseq_pkg::*;
#(
   parameter int           AW          = 14,
   parameter int           SYNC_STAGES = 2,
   parameter int           STORE_CYC   = 2_000_000,
   parameter int           RECALL_CYC  = 4_000,
   parameter logic [AW-1:0] UNLK0       = AW'(14'h0E38),
   parameter logic [AW-1:0] UNLK1       = AW'(14'h31C7),
   parameter logic [AW-1:0] UNLK2       = AW'(14'h03E0),
   parameter logic [AW-1:0] UNLK3       = AW'(14'h3C1F),
   parameter logic [AW-1:0] UNLK4       = AW'(14'h303F),
   parameter logic [AW-1:0] SEL_STORE   = AW'(14'h0FC0),
   parameter logic [AW-1:0] SEL_RECALL  = AW'(14'h0C63)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          ce_n_i,
   input  logic          we_n_i,
   input  logic          oe_n_i,
   input  logic          pwr_ok_i,
   output logic          busy_o,
   output logic          store_act_o,
   output logic          recall_act_o,
   output logic          store_done_o,
   output logic          recall_done_o,
   output logic          store_abort_o,
   output logic          dq_oe_o
);
   localparam int BW = AW + 2;
   localparam logic [BW-1:0] BUS_IDLE = {2'b11, {AW{1'b0}}};

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (STORE_CYC < 1 || RECALL_CYC < 1) begin : g_bad_len
      $error("cycle lengths must be at least 1");
   end
   if (SEL_STORE == SEL_RECALL) begin : g_bad_sel
      $error("store and recall selectors must differ");
   end

   logic [BW-1:0] bus_s;
   logic          ce_s, we_s, ce_prev;
   logic [AW-1:0] addr_s;
   logic          evt;
   nv_req_e       req;

   nvseq_sync #(
      .W       (BW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ce_n_i, we_n_i, addr_i}),
      .q_o   (bus_s)
   );

   assign {ce_s, we_s, addr_s} = bus_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_prev <= 1'b1;
      else        ce_prev <= ce_s;
   end

   assign evt = ce_prev & ~ce_s;

   nvseq_matcher #(
      .AW         (AW),
      .UNLK0      (UNLK0),
      .UNLK1      (UNLK1),
      .UNLK2      (UNLK2),
      .UNLK3      (UNLK3),
      .UNLK4      (UNLK4),
      .SEL_STORE  (SEL_STORE),
      .SEL_RECALL (SEL_RECALL)
   ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (busy_o | ~pwr_ok_i),
      .evt_i   (evt),
      .rd_i    (we_s),
      .addr_i  (addr_s),
      .req_o   (req)
   );

   nvseq_cycle_ctrl #(
      .STORE_CYC  (STORE_CYC),
      .RECALL_CYC (RECALL_CYC)
   ) u_cyc (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwr_ok_i      (pwr_ok_i),
      .req_i         (req),
      .store_act_o   (store_act_o),
      .recall_act_o  (recall_act_o),
      .store_done_o  (store_done_o),
      .recall_done_o (recall_done_o),
      .store_abort_o (store_abort_o)
   );

   assign busy_o  = store_act_o | recall_act_o;
   assign dq_oe_o = ~busy_o & ~ce_n_i & ~oe_n_i & we_n_i;
endmodule

// File: rtl/nvsram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module nvsram_seq_ctrl_chk #(
   parameter int STORE_CYC  = 2_000_000,
   parameter int RECALL_CYC = 4_000
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_ok_i,
   input logic busy_o,
   input logic store_act_o,
   input logic recall_act_o,
   input logic store_done_o,
   input logic recall_done_o,
   input logic store_abort_o,
   input logic dq_oe_o
);
   logic [31:0] st_len, rc_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_len <= '0;
         rc_len <= '0;
      end else begin
         st_len <= store_act_o  ? st_len + 32'd1 : 32'd0;
         rc_len <= recall_act_o ? rc_len + 32'd1 : 32'd0;
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> !busy_o && !store_done_o && !recall_done_o && !store_abort_o); // R1

   AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_act_o, recall_act_o})); // R3

   AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_done_o, recall_done_o, store_abort_o})); // R3

   AST_STORE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(store_act_o) && store_done_o |-> st_len == 32'(STORE_CYC)); // R3

   AST_RECALL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(recall_act_o) |-> recall_done_o && rc_len == 32'(RECALL_CYC)); // R12

   AST_AUTO_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_ok_i) && !busy_o |=> recall_act_o); // R2

   AST_STORE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      store_act_o && !pwr_ok_i |=> !store_act_o && store_abort_o && !store_done_o); // R11

   AST_NO_STORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(store_act_o) |-> $past(pwr_ok_i)); // R13

   AST_DQ_OFF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !dq_oe_o); // R10

   AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      store_act_o |=> store_act_o || store_done_o || store_abort_o); // R9
endmodule

bind nvsram_seq_ctrl nvsram_seq_ctrl_chk #(
   .STORE_CYC  (STORE_CYC),
   .RECALL_CYC (RECALL_CYC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pwr_ok_i      (pwr_ok_i),
   .busy_o        (busy_o),
   .store_act_o   (store_act_o),
   .recall_act_o  (recall_act_o),
   .store_done_o  (store_done_o),
   .recall_done_o (recall_done_o),
   .store_abort_o (store_abort_o),
   .dq_oe_o       (dq_oe_o)
);

// File: tb/nvsram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module nvsram_seq_ctrl_bench;
   localparam int AW  = 14;
   localparam int SC  = 40;
   localparam int RC  = 12;
   localparam int NV  = 8;
   localparam logic [AW-1:0] A0 = 14'h0E38, A1 = 14'h31C7, A2 = 14'h03E0,
                             A3 = 14'h3C1F, A4 = 14'h303F,
                             AS = 14'h0FC0, AR = 14'h0C63;

   // sequences, write-flag masks (bit s = access s is a write), expected: 0 none, 1 store, 2 recall
   localparam logic [AW-1:0] VA [NV][6] = '{
      '{A0, A1, A2, A3, A4, AS},        // R3
      '{A0, A1, A2, A3, A4, AR},        // R4
      '{A0, A1, A2, A3, A4, 14'h0000},  // R5
      '{A0, A0, A1, A2, A3, A4},        // R6 repeat
      '{A0, A2, A1, A2, A3, A4},        // R6 order
      '{A0, A1, A2, A3, A4, AS},        // R7 write at step 2
      '{A0, A1, A2, A3, A4, AS},        // R7 write at step 5
      '{A0, A1, A2, A3, A4, AS}         // R5 recovery
   };
   localparam logic [5:0] VWR [NV] = '{6'b000000, 6'b000000, 6'b000000, 6'b000000,
                                       6'b000000, 6'b000100, 6'b100000, 6'b000000};
   localparam int VEXP [NV] = '{1, 2, 0, 0, 0, 0, 0, 1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          ce_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b1, pwr_ok_i = 1'b0;
   logic          busy_o, store_act_o, recall_act_o, store_done_o, recall_done_o;
   logic          store_abort_o, dq_oe_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   nvsram_seq_ctrl #(
      .AW (AW), .SYNC_STAGES (2), .STORE_CYC (SC), .RECALL_CYC (RC)
   ) u_nvsram_seq_ctrl (
      .clk (clk), .rst_n (rst_n), .addr_i (addr_i), .ce_n_i (ce_n_i),
      .we_n_i (we_n_i), .oe_n_i (oe_n_i), .pwr_ok_i (pwr_ok_i),
      .busy_o (busy_o), .store_act_o (store_act_o), .recall_act_o (recall_act_o),
      .store_done_o (store_done_o), .recall_done_o (recall_done_o),
      .store_abort_o (store_abort_o), .dq_oe_o (dq_oe_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic access(input logic [AW-1:0] a, input logic wr, input int lo, input int gap);
      @(negedge clk);
      addr_i = a; we_n_i = ~wr; ce_n_i = 1'b0;
      repeat (lo) @(negedge clk);
      ce_n_i = 1'b1; we_n_i = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic run_seq(input int v, input int lo);
      for (int s = 0; s < 6; s++)
         access(VA[v][s], VWR[v][s], lo, (s == 5) ? 0 : 2);
   endtask

   task automatic expect_cycle(input string req, input int kind, input int n);
      int w = 0;
      int len = 0;
      while (!busy_o && w < 12) begin @(negedge clk); w++; end
      chk({req, " start"}, int'(busy_o), 1);
      chk({req, " kind"}, int'(kind == 1 ? store_act_o : recall_act_o), 1);
      while (busy_o && len < n + 20) begin len++; @(negedge clk); end
      chk({req, " length"}, len, n);
      chk({req, " done"}, int'(kind == 1 ? store_done_o : recall_done_o), 1);
      chk({req, " other pulses"},
          int'(kind == 1 ? recall_done_o : store_done_o) + int'(store_abort_o), 0);
      @(negedge clk);
      chk({req, " done width"}, int'(store_done_o) + int'(recall_done_o), 0);
   endtask

   task automatic no_start(input string req);
      int seen = 0;
      repeat (12) begin @(negedge clk); if (busy_o) seen++; end
      chk({req, " no cycle"}, seen, 0);
   endtask

   initial begin
      #(200_000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy_o), 0);
      chk("R1 pulses in reset", int'(store_done_o) + int'(recall_done_o) + int'(store_abort_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 idle after reset", int'(busy_o) + int'(store_act_o) + int'(recall_act_o), 0);

      // R2 power-up restore
      pwr_ok_i = 1'b1;
      expect_cycle("R2 power-up", 2, RC);

      // table walk, pulse widths 1..3 clocks (R8 for width 1)
      for (int v = 0; v < NV; v++) begin
         run_seq(v, 1 + (v % 3));
         if (VEXP[v] == 0) no_start($sformatf("R5/R6/R7 vec%0d", v));
         else expect_cycle($sformatf("R3/R4/R8 vec%0d", v), VEXP[v], VEXP[v] == 1 ? SC : RC);
      end
      run_seq(1, 1);
      expect_cycle("R8 single-clock pulses", 2, RC);

      // R10 output enable
      @(negedge clk);
      addr_i = '0; oe_n_i = 1'b0; we_n_i = 1'b1; ce_n_i = 1'b0;
      #1 chk("R10 read idle", int'(dq_oe_o), 1);
      we_n_i = 1'b0;
      #1 chk("R10 write", int'(dq_oe_o), 0);
      we_n_i = 1'b1; oe_n_i = 1'b1;
      #1 chk("R10 G high", int'(dq_oe_o), 0);
      ce_n_i = 1'b1;
      repeat (4) @(negedge clk);

      // R9 + R10 inputs ignored while busy
      run_seq(0, 1);
      while (!busy_o) @(negedge clk);
      oe_n_i = 1'b0;
      for (int s = 0; s < 6; s++) begin
         access(VA[1][s], 1'b0, 1, 2);
         if (s == 0) begin
            @(negedge clk);
            ce_n_i = 1'b0;
            #1 chk("R10 busy drivers off", int'(dq_oe_o), 0);
            ce_n_i = 1'b1;
            repeat (3) @(negedge clk);
         end
      end
      oe_n_i = 1'b1;
      chk("R9 store still running", int'(store_act_o), 1);
      while (busy_o) @(negedge clk);
      chk("R9 store completed", int'(store_done_o), 1);
      no_start("R9 pattern during busy");

      // R11 save aborted by supply loss
      run_seq(0, 1);
      while (!busy_o) @(negedge clk);
      repeat (5) @(negedge clk);
      pwr_ok_i = 1'b0;
      @(negedge clk);
      chk("R11 store stopped", int'(store_act_o), 0);
      chk("R11 abort pulse", int'(store_abort_o), 1);
      chk("R11 no done", int'(store_done_o), 0);
      @(negedge clk);
      chk("R11 abort width", int'(store_abort_o), 0);
      pwr_ok_i = 1'b1;
      expect_cycle("R2 restore after abort", 2, RC);

      // R12 restore survives supply loss
      run_seq(1, 1);
      fork
         expect_cycle("R12 restore full", 2, RC);
         begin repeat (5) @(negedge clk); pwr_ok_i = 1'b0; end
      join
      pwr_ok_i = 1'b1;
      expect_cycle("R2 restore after R12", 2, RC);

      // R13 no save while supply low
      pwr_ok_i = 1'b0;
      @(negedge clk);
      run_seq(0, 1);
      no_start("R13 supply low");
      pwr_ok_i = 1'b1;
      expect_cycle("R2 restore after R13", 2, RC);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule